// File: doc/BRIEF.md
# Masked MAC and multicast hash filter

This block decides whether an incoming 48-bit destination MAC address is accepted. Sixteen programmable station entries each hold an address and a 48-bit don't-care mask. A per-entry enable vector selects which entries take part. When several entries match, the lowest-numbered one is reported. Next to the exact-address path, a multicast path computes the Ethernet CRC-32 of the six address octets. Eight bits of that CRC pick one bit of a 256-bit bitmap, and a 1 there counts as a hash hit.

The address arrives on a one-cycle strobe, `da_valid`, together with `da_addr`. The block accepts one address on every cycle and never applies back-pressure, so the input carries no ready signal. The verdict is registered. It appears on `res_valid`, `accept`, `addr_hit`, `match_idx` and `hash_hit` in the cycle after the strobe, and it holds until the next strobe. Software loads station entries through a plain write port, one entry per write. It loads the bitmap in 16-bit slices through a second write port. The enable vector and the hash enable are plain level inputs, sampled on the strobe cycle.

Top module: `mac_da_filter`

## Requirements
- R1: An enabled entry i matches when `((da_addr ^ addr_i) & ~mask_i) == 0`, so every mask bit set to 1 makes the matching address bit a don't-care. An entry whose mask is all ones matches any address.
- R2: Entry i takes part only while bit i of `entry_en` is 1 (bit 0 enables entry 0). With a 0 in that bit, the entry never causes `addr_hit`.
- R3: When several enabled entries match, `match_idx` reports the lowest index. When no entry matches, `addr_hit` is 0 and `match_idx` is 0.
- R4: The first octet of the address, as written in hyphenated form, is `da_addr[47:40]`, and the last octet is `da_addr[7:0]`. The multicast (group) bit is `da_addr[40]`.
- R5: The hash is the bit-reflected Ethernet CRC-32 (polynomial 0xEDB88320, seed 0xFFFFFFFF, no final complement). It is taken over the octets in order from first to last, each octet least-significant bit first. Bits 31:24 of the resulting register form an index into the 256-bit bitmap, and a 1 at that index is a hash hit.
- R6: A bitmap write of slice s with data d sets bitmap bits `16*s+15 : 16*s` to d. Slice 0 holds bits 15:0 and slice 15 holds bits 255:240.
- R7: `hash_hit` is 1 only if `hash_en` was 1 on the strobe cycle, `da_addr[40]` was 1, and the indexed bitmap bit was 1. A unicast address never produces a hash hit.
- R8: `accept` equals `addr_hit` OR `hash_hit`. All results are registered: `res_valid` is high exactly in the cycle after each strobe, and the result outputs hold their values until the next strobe.
- R9: An entry write or bitmap write takes effect at the clock edge that samples it. A strobe in the same cycle as a write sees the old contents, and a strobe in any later cycle sees the new contents.
- R10: Reset clears all result outputs, every station entry (address and mask to 0) and the whole bitmap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| da_valid | input | 1 | Strobe: `da_addr` holds an address to classify |
| da_addr | input | 48 | Destination address, first octet in bits 47:40 |
| entry_en | input | 16 | Per-entry enable, bit i enables entry i |
| hash_en | input | 1 | Enables the multicast bitmap check |
| ent_wr | input | 1 | Write strobe for one station entry |
| ent_wr_idx | input | 4 | Entry written |
| ent_wr_addr | input | 48 | Address value written to the entry |
| ent_wr_mask | input | 48 | Don't-care mask written to the entry |
| hash_wr | input | 1 | Write strobe for one bitmap slice |
| hash_wr_slice | input | 4 | Slice written |
| hash_wr_data | input | 16 | Slice contents |
| res_valid | output | 1 | High for one cycle, one cycle after each strobe |
| accept | output | 1 | Address accepted |
| addr_hit | output | 1 | Some enabled entry matched |
| match_idx | output | 4 | Lowest matching entry, 0 if none |
| hash_hit | output | 1 | Multicast bitmap hit |

## Verification
Every result of a strobe is due exactly one rising edge after the edge that samples `da_valid`. The CRC, the entry compare and the priority pick are all combinational in front of that single register stage. The bench therefore drives each strobe on a falling edge and reads all five result outputs on the next falling edge, when they are settled. Writes land on the edge that samples them, so the bench places a strobe in the same cycle as a write to check that the strobe sees the old contents, and a strobe in the next cycle to check that it sees the new contents. For the hold behaviour, the bench also reads the outputs again after idle cycles.

// File: rtl/mdf_pkg.sv
package mdf_pkg;

  localparam int MAC_W       = 48;
  localparam int OCTET_W     = 8;
  localparam int OCTETS      = MAC_W / OCTET_W;
  localparam int GROUP_BIT   = MAC_W - OCTET_W;   // lsb of the first octet
  localparam int CRC_W       = 32;
  localparam logic [CRC_W-1:0] CRC_POLY_REV = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_SEED     = 32'hFFFFFFFF;

  // Reflected CRC-32 over the address octets, first octet first,
  // each octet least significant bit first; no final complement.
  function automatic logic [CRC_W-1:0] da_crc(input logic [MAC_W-1:0] da);
    logic [CRC_W-1:0]   r;
    logic [OCTET_W-1:0] oct;
    r = CRC_SEED;
    for (int o = 0; o < OCTETS; o++) begin
      oct = da[MAC_W-1-OCTET_W*o -: OCTET_W];
      for (int k = 0; k < OCTET_W; k++) begin
        if (r[0] ^ oct[k]) r = (r >> 1) ^ CRC_POLY_REV;
        else               r = r >> 1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/mdf_entry_bank.sv
module mdf_entry_bank #(
  parameter int N_ENT = 16,
  parameter int AW    = 48,
  localparam int IW   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] wr_mask,
  input  logic [AW-1:0] probe,
  input  logic [N_ENT-1:0] enable,
  output logic [N_ENT-1:0] hit
);

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic [AW-1:0] addr_q;
    logic [AW-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
        mask_q <= '0;
      end else if (wr_en && (wr_idx == IW'(g))) begin
        addr_q <= wr_addr;
        mask_q <= wr_mask;
      end
    end

    // mask bit 1 = don't care
    assign hit[g] = enable[g] && (((probe ^ addr_q) & ~mask_q) == '0);
  end

endmodule

// File: rtl/mdf_first_hit.sv
module mdf_first_hit #(
  parameter int N_ENT = 16,
  localparam int IW   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic [N_ENT-1:0] vec,
  output logic             any,
  output logic [IW-1:0]    idx
);

  assign any = |vec;

  // scan downward so the lowest set index wins
  always_comb begin
    idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/mdf_hash_lookup.sv
module mdf_hash_lookup
  import mdf_pkg::*;
#(
  parameter int SLICE_W = 16,
  parameter int SLICES  = 16,
  localparam int TBL    = SLICE_W * SLICES,
  localparam int IDX_W  = $clog2(TBL),
  localparam int SEL_W  = (SLICES > 1) ? $clog2(SLICES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_slice,
  input  logic [SLICE_W-1:0] wr_data,
  input  logic [MAC_W-1:0]   probe,
  input  logic               enable,
  output logic               hit
);

  logic [TBL-1:0]   bitmap;
  logic [CRC_W-1:0] crc;
  logic [IDX_W-1:0] sel;

  for (genvar s = 0; s < SLICES; s++) begin : g_slice
    logic [SLICE_W-1:0] row_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   row_q <= '0;
      else if (wr_en && (wr_slice == SEL_W'(s)))    row_q <= wr_data;
    end

    assign bitmap[s*SLICE_W +: SLICE_W] = row_q;
  end

  assign crc = da_crc(probe);
  assign sel = crc[CRC_W-1 -: IDX_W];
  assign hit = enable && probe[GROUP_BIT] && bitmap[sel];

endmodule

// File: rtl/mac_da_filter.sv
module mac_da_filter
  import mdf_pkg::*;
#(
  parameter int N_ENT        = 16,
  parameter int HASH_SLICE_W = 16,
  parameter int HASH_SLICES  = 16,
  localparam int IW          = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int SEL_W       = (HASH_SLICES > 1) ? $clog2(HASH_SLICES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    da_valid,
  input  logic [MAC_W-1:0]        da_addr,
  input  logic [N_ENT-1:0]        entry_en,
  input  logic                    hash_en,
  input  logic                    ent_wr,
  input  logic [IW-1:0]           ent_wr_idx,
  input  logic [MAC_W-1:0]        ent_wr_addr,
  input  logic [MAC_W-1:0]        ent_wr_mask,
  input  logic                    hash_wr,
  input  logic [SEL_W-1:0]        hash_wr_slice,
  input  logic [HASH_SLICE_W-1:0] hash_wr_data,
  output logic                    res_valid,
  output logic                    accept,
  output logic                    addr_hit,
  output logic [IW-1:0]           match_idx,
  output logic                    hash_hit
);

  logic [N_ENT-1:0] hit_vec;
  logic             any_hit;
  logic [IW-1:0]    first_idx;
  logic             bitmap_hit;

  mdf_entry_bank #(.N_ENT(N_ENT), .AW(MAC_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ent_wr),
    .wr_idx  (ent_wr_idx),
    .wr_addr (ent_wr_addr),
    .wr_mask (ent_wr_mask),
    .probe   (da_addr),
    .enable  (entry_en),
    .hit     (hit_vec)
  );

  mdf_first_hit #(.N_ENT(N_ENT)) u_pick (
    .vec (hit_vec),
    .any (any_hit),
    .idx (first_idx)
  );

  mdf_hash_lookup #(.SLICE_W(HASH_SLICE_W), .SLICES(HASH_SLICES)) u_hash (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (hash_wr),
    .wr_slice (hash_wr_slice),
    .wr_data  (hash_wr_data),
    .probe    (da_addr),
    .enable   (hash_en),
    .hit      (bitmap_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      accept    <= 1'b0;
      addr_hit  <= 1'b0;
      match_idx <= '0;
      hash_hit  <= 1'b0;
    end else begin
      res_valid <= da_valid;
      if (da_valid) begin
        accept    <= any_hit | bitmap_hit;
        addr_hit  <= any_hit;
        match_idx <= first_idx;
        hash_hit  <= bitmap_hit;
      end
    end
  end

endmodule

// File: rtl/mdf_checker.sv
module mdf_checker #(
  parameter int N_ENT = 16,
  parameter int IW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             da_valid,
  input logic [47:0]      da_addr,
  input logic [N_ENT-1:0] entry_en,
  input logic             hash_en,
  input logic             res_valid,
  input logic             accept,
  input logic             addr_hit,
  input logic [IW-1:0]    match_idx,
  input logic             hash_hit
);

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> res_valid);

  assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> !res_valid);

  assert_accept_is_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (accept == (addr_hit | hash_hit)));

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> ($stable(accept) && $stable(addr_hit) && $stable(hash_hit) && $stable(match_idx)));

  assert_disabled_entries_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && (entry_en == '0)) |=> !addr_hit);

  assert_no_miss_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !addr_hit) |-> (match_idx == '0));

  assert_hash_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !hash_en) |=> !hash_hit);

  assert_unicast_no_hash_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !da_addr[40]) |=> !hash_hit);

endmodule

bind mac_da_filter mdf_checker #(.N_ENT(N_ENT), .IW(IW)) u_mdf_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .da_valid  (da_valid),
  .da_addr   (da_addr),
  .entry_en  (entry_en),
  .hash_en   (hash_en),
  .res_valid (res_valid),
  .accept    (accept),
  .addr_hit  (addr_hit),
  .match_idx (match_idx),
  .hash_hit  (hash_hit)
);

// File: tb/tb_mac_da_filter.sv
module tb_mac_da_filter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        da_valid = 1'b0;
  logic [47:0] da_addr = '0;
  logic [15:0] entry_en = '0;
  logic        hash_en = 1'b0;
  logic        ent_wr = 1'b0;
  logic [3:0]  ent_wr_idx = '0;
  logic [47:0] ent_wr_addr = '0;
  logic [47:0] ent_wr_mask = '0;
  logic        hash_wr = 1'b0;
  logic [3:0]  hash_wr_slice = '0;
  logic [15:0] hash_wr_data = '0;
  logic        res_valid, accept, addr_hit, hash_hit;
  logic [3:0]  match_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [255:0] tbl_m = '0;

  always #10 clk = ~clk;   // 50 MHz

  mac_da_filter dut (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_addr(da_addr),
    .entry_en(entry_en), .hash_en(hash_en), .ent_wr(ent_wr),
    .ent_wr_idx(ent_wr_idx), .ent_wr_addr(ent_wr_addr), .ent_wr_mask(ent_wr_mask),
    .hash_wr(hash_wr), .hash_wr_slice(hash_wr_slice), .hash_wr_data(hash_wr_data),
    .res_valid(res_valid), .accept(accept), .addr_hit(addr_hit),
    .match_idx(match_idx), .hash_hit(hash_hit)
  );

  // Forward-form CRC-32 (0x04C11DB7) on the same bit stream; the
  // reflected register's bits 31:24 are the reverse of bits 7:0 here.
  function automatic logic [7:0] model_idx(input logic [47:0] da);
    logic [31:0] c;
    logic [7:0]  b;
    logic        fb;
    logic [7:0]  r;
    c = 32'hFFFFFFFF;
    for (int o = 0; o < 6; o++) begin
      b = da[47-8*o -: 8];
      for (int k = 0; k < 8; k++) begin
        fb = c[31] ^ b[k];
        c  = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    for (int j = 0; j < 8; j++) r[j] = c[7-j];
    return r;
  endfunction

  function automatic logic [47:0] find_mc(input logic [7:0] want);
    logic [47:0] cand;
    for (int v = 0; v < 65536; v++) begin
      cand = {24'h01005E, 8'h00, 16'(v)};
      if (model_idx(cand) == want) return cand;
    end
    return 48'h0;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic write_entry(input logic [3:0] idx, input logic [47:0] a,
                             input logic [47:0] m);
    @(negedge clk);
    ent_wr = 1'b1; ent_wr_idx = idx; ent_wr_addr = a; ent_wr_mask = m;
    @(negedge clk);
    ent_wr = 1'b0;
  endtask

  task automatic write_slice(input int s, input logic [15:0] d);
    @(negedge clk);
    hash_wr = 1'b1; hash_wr_slice = 4'(s); hash_wr_data = d;
    tbl_m[s*16 +: 16] = d;
    @(negedge clk);
    hash_wr = 1'b0;
  endtask

  // strobe one address; results read one edge later
  task automatic probe(input logic [47:0] da, input logic [15:0] en, input logic hen,
                       input logic e_ahit, input logic [3:0] e_idx, input string req);
    logic e_hash;
    e_hash = hen & da[40] & tbl_m[model_idx(da)];
    @(negedge clk);
    da_valid = 1'b1; da_addr = da; entry_en = en; hash_en = hen;
    @(negedge clk);
    da_valid = 1'b0;
    check(req, "res_valid", 64'(res_valid), 64'd1);
    check(req, "addr_hit",  64'(addr_hit),  64'(e_ahit));
    check(req, "match_idx", 64'(match_idx), 64'(e_idx));
    check(req, "hash_hit",  64'(hash_hit),  64'(e_hash));
    check(req, "accept",    64'(accept),    64'(e_ahit | e_hash));
  endtask

  // {da[47:0], entry_en[15:0], hash_en, exp_addr_hit, exp_idx[3:0]}
  localparam logic [69:0] VEC [10] = '{
    {48'h020000000010, 16'h002B, 1'b0, 1'b1, 4'd0},   // R1 exact, overlaps entry 1
    {48'h020000000077, 16'h002B, 1'b0, 1'b1, 4'd1},   // R1 partial via mask
    {48'h01005E123456, 16'h002B, 1'b0, 1'b1, 4'd3},   // R1 multicast range
    {48'h01005E923456, 16'h002B, 1'b0, 1'b0, 4'd0},   // R1 cared bit differs
    {48'hAABBCCDDEEFF, 16'h002B, 1'b0, 1'b1, 4'd5},   // R1 exact entry 5
    {48'hAABBCCDDEEFF, 16'h0003, 1'b0, 1'b0, 4'd0},   // R2 entry 5 disabled
    {48'h020000000010, 16'h0002, 1'b0, 1'b1, 4'd1},   // R2 entry 0 off
    {48'h123456789ABC, 16'h8000, 1'b0, 1'b1, 4'd15},  // R1 all-ones mask
    {48'h123456789ABC, 16'h8001, 1'b1, 1'b1, 4'd15},  // R3 only 15 matches
    {48'h020000000010, 16'hFFFF, 1'b1, 1'b1, 4'd0}    // R3 lowest of 0,1,15
  };

  initial begin
    logic [47:0] mc_a, mc_hi, mc_lo;
    // R10: reset state
    repeat (3) @(negedge clk);
    check("R10", "res_valid", 64'(res_valid), 64'd0);
    check("R10", "accept",    64'(accept),    64'd0);
    check("R10", "addr_hit",  64'(addr_hit),  64'd0);
    check("R10", "match_idx", 64'(match_idx), 64'd0);
    check("R10", "hash_hit",  64'(hash_hit),  64'd0);
    rst_n = 1'b1;
    // R10: cleared bitmap and cleared entries (addr 0, mask 0)
    probe(48'h01005E0A0B0C, 16'hFFFF, 1'b1, 1'b0, 4'd0, "R10");

    write_entry(4'd0,  48'h020000000010, 48'h000000000000);
    write_entry(4'd1,  48'h020000000000, 48'h0000000000FF);
    write_entry(4'd3,  48'h01005E000000, 48'h0000007FFFFF);
    write_entry(4'd5,  48'hAABBCCDDEEFF, 48'h000000000000);
    write_entry(4'd15, 48'h000000000000, 48'hFFFFFFFFFFFF);

    for (int v = 0; v < 10; v++) begin
      probe(VEC[v][69:22], VEC[v][21:6], VEC[v][5], VEC[v][4], VEC[v][3:0], "R1/R2/R3 vector");
    end

    // R5/R7: one programmed bitmap bit
    mc_a = 48'h01005E010203;
    write_slice(int'(model_idx(mc_a)) / 16, 16'(1) << (model_idx(mc_a) % 16));
    probe(mc_a, 16'h0000, 1'b1, 1'b0, 4'd0, "R5");
    check("R5", "hash_hit set", 64'(hash_hit), 64'd1);
    probe(mc_a, 16'h0000, 1'b0, 1'b0, 4'd0, "R7");
    check("R7", "hash_en off", 64'(hash_hit), 64'd0);

    // R6: slice boundaries (bits 255 and 0)
    mc_hi = find_mc(8'd255);
    mc_lo = find_mc(8'd0);
    check("R6", "index 255 found", 64'(mc_hi[40]), 64'd1);
    check("R6", "index 0 found",   64'(mc_lo[40]), 64'd1);
    write_slice(15, 16'h8000);
    write_slice(0,  16'h0001);
    probe(mc_hi, 16'h0000, 1'b1, 1'b0, 4'd0, "R6");
    check("R6", "bit 255", 64'(hash_hit), 64'd1);
    probe(mc_lo, 16'h0000, 1'b1, 1'b0, 4'd0, "R6");
    check("R6", "bit 0", 64'(hash_hit), 64'd1);

    // R8: results hold while no strobe arrives
    @(negedge clk);
    @(negedge clk);
    check("R8", "res_valid idle", 64'(res_valid), 64'd0);
    check("R8", "accept held",    64'(accept),    64'd1);
    check("R8", "hash_hit held",  64'(hash_hit),  64'd1);

    // R9: write and strobe in the same cycle see old contents
    @(negedge clk);
    ent_wr = 1'b1; ent_wr_idx = 4'd0; ent_wr_addr = 48'h0A0000000001; ent_wr_mask = '0;
    da_valid = 1'b1; da_addr = 48'h020000000010; entry_en = 16'h0001; hash_en = 1'b0;
    @(negedge clk);
    ent_wr = 1'b0; da_valid = 1'b0;
    check("R9", "old entry hit", 64'(addr_hit), 64'd1);
    probe(48'h0A0000000001, 16'h0001, 1'b0, 1'b1, 4'd0, "R9");
    probe(48'h020000000010, 16'h0001, 1'b0, 1'b0, 4'd0, "R9");

    // R4/R7: full bitmap, unicast never hashes, multicast always does
    for (int s = 0; s < 16; s++) write_slice(s, 16'hFFFF);
    probe(48'h020000000099, 16'h0000, 1'b1, 1'b0, 4'd0, "R4");
    check("R4", "unicast no hash", 64'(hash_hit), 64'd0);
    probe(48'h03AABBCCDDEE, 16'h0000, 1'b1, 1'b0, 4'd0, "R4");
    check("R4", "group bit hash", 64'(hash_hit), 64'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule